// File: doc/BRIEF.md
# Serial Transmit Path with Character Queue and Line Break

This block is the sending half of an asynchronous serial port. Software places characters one at a time into a 16-deep queue. A frame engine takes them out in order and turns each into a frame on the serial output. The frame format and the bit-rate divisor come from the line control word and the divisor input, which the receiving half also reads. The queue's fill level can be read back from the same word that software writes, so a driver knows how much room is left before it pushes more.

Two sticky status flags tell software how far the transmitter has drained. The first rises when the last queued character has been handed to the frame engine, which means the queue has room for a full refill. The second rises when the final stop bit of the last frame has left the line, which means the port is completely quiet. Both flags stay set until software writes ones to the matching positions of the clear word. A break control holds the line low for as long as it is set, and a flush control empties the queue.

The frame engine is a state machine with these states:
- TX_IDLE: the line is high. The engine moves to TX_START and takes one character from the queue whenever the queue is not empty.
- TX_START: the start bit is sent low. The engine moves to TX_DATA after one bit period.
- TX_DATA: 7 or 8 data bits are sent, least significant first. After the last data bit the engine moves to TX_PARITY when parity is on, and to TX_STOP1 otherwise.
- TX_PARITY: the parity bit is sent. The engine then moves to TX_STOP1.
- TX_STOP1: the first stop bit is sent high. The engine moves to TX_STOP2 when two stop bits are selected, and back to TX_IDLE otherwise.
- TX_STOP2: the second stop bit is sent high. The engine then returns to TX_IDLE.

Top module: `uart_tx_path`

## Requirements
- R1: A cycle with `fifo_wr` high pushes `fifo_wdata` into the queue. `fifo_rdata[20:16]` shows the fill level, and every other bit of `fifo_rdata` reads zero.
- R2: The line idles high. Each frame is one low start bit, then the data bits least significant first, then parity when enabled, then the stop bits. `lcr[24]`=1 selects 8 data bits; `lcr[24]`=0 selects 7 data bits (the low 7 bits of the character).
- R3: `lcr[27]`=1 adds a parity bit. With `lcr[28]`=1 the parity is even, so the data bits plus the parity bit hold an even number of ones; with `lcr[28]`=0 the parity is odd. `lcr[26]`=1 sends two high stop bits; `lcr[26]`=0 sends one.
- R4: Every bit on the line lasts exactly (`divisor`+1)×16 clock cycles.
- R5: The queue holds 16 characters. A push while the level is 16 is ignored, and the level stays at 16.
- R6: While `lcr[18]` is high the queue is emptied, and the level reads 0 from the next cycle on.
- R7: While `lcr[30]` is high, `txd` is low from the next cycle on. After `lcr[30]` is released with nothing to send, `txd` returns high.
- R8: `int_status[7]` becomes 1 one clock after the cycle in which the last queued character moves into the frame engine.
- R9: `int_status[6]` becomes 1 once the final stop bit of a frame has completed with the queue empty. It stays 0 while a frame is still on the line.
- R10: A cycle with `iclr_wr` high clears each `int_status` bit among 7 and 6 that is 1 in `iclr_data`, and leaves the other flag untouched. After reset the level is 0, `int_status` is 0 and `txd` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_wr | input | 1 | Push strobe for the transmit queue |
| fifo_wdata | input | 8 | Character to push |
| fifo_rdata | output | 32 | Queue read-back word; fill level in bits 20:16 |
| lcr | input | 32 | Line control: 30 break, 28 even parity, 27 parity on, 26 two stops, 24 eight bits, 18 flush |
| divisor | input | DIV_W | Bit period is (divisor+1)×16 clocks |
| iclr_wr | input | 1 | Status clear strobe |
| iclr_data | input | 32 | Ones in bits 7 and 6 clear the matching flags |
| int_status | output | 8 | Bit 7 queue drained, bit 6 transmitter fully idle; other bits 0 |
| txd | output | 1 | Serial output |

## Verification
The bench builds the block with DEPTH=16 and DIV_W=8, so the fill-level field is exactly five bits wide and the full-queue boundary at 16 is the real one. Divisors of 0 to 2 keep frames short enough that many randomly formatted frames fit in the run, and each frame is sampled in the middle of every bit, so a period error of one clock per bit shows up as drift. A divisor of 7 makes the first frame long enough that a burst of twenty pushes fills the queue and overruns it while one character is still on the line.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP1,
        TX_STOP2
    } tx_state_e;

    typedef struct packed {
        logic word8;
        logic par_en;
        logic par_even;
        logic two_stop;
    } frame_fmt_t;

    // line control positions, decoded by the receiving half as well
    localparam int LC_BREAK    = 30;
    localparam int LC_PAR_EVEN = 28;
    localparam int LC_PAR_EN   = 27;
    localparam int LC_TWO_STOP = 26;
    localparam int LC_WORD8    = 24;
    localparam int LC_FLUSH    = 18;

    localparam int ST_DRAINED  = 7;
    localparam int ST_QUIET    = 6;
    localparam int LEVEL_LSB   = 16;
endpackage

// File: rtl/tx_queue.sv
module tx_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    input  logic          flush,
    output logic [W-1:0]  rdata,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign push_ok = push && (level < LW'(DEPTH));
    assign pop_ok  = pop && (level != '0);
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            if (push_ok && !pop_ok)      level <= level + 1'b1;
            else if (pop_ok && !push_ok) level <= level - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wr_ptr] <= wdata;
    end

    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    // R5
    full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && level == LW'(DEPTH) && !pop && !flush) |=> (level == LW'(DEPTH)));
    // R6
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));
endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          tick
);
    logic [CW-1:0] count;

    assign tick = run && (count == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              count <= '0;
        else if (!run || tick)   count <= '0;
        else                     count <= count + 1'b1;
    end
endmodule

// File: rtl/tx_framer.sv
module tx_framer
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       avail,
    input  logic [7:0] data,
    input  frame_fmt_t fmt,
    input  logic       tick,
    output logic       take,
    output logic       line,
    output logic       frame_done,
    output tx_state_e  state
);
    tx_state_e  nxt;
    frame_fmt_t fmt_q;
    logic [7:0] shreg;
    logic [2:0] bit_idx;
    logic       par_bit;
    logic       ones;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:   if (avail) nxt = TX_START;
            TX_START:  if (tick) nxt = TX_DATA;
            TX_DATA:   if (tick && bit_idx == (fmt_q.word8 ? 3'd7 : 3'd6))
                           nxt = fmt_q.par_en ? TX_PARITY : TX_STOP1;
            TX_PARITY: if (tick) nxt = TX_STOP1;
            TX_STOP1:  if (tick) nxt = fmt_q.two_stop ? TX_STOP2 : TX_IDLE;
            TX_STOP2:  if (tick) nxt = TX_IDLE;
            default:   nxt = TX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        take       = 1'b0;
        line       = 1'b1;
        frame_done = 1'b0;
        unique case (state)
            TX_IDLE:   take = avail;
            TX_START:  line = 1'b0;
            TX_DATA:   line = shreg[0];
            TX_PARITY: line = par_bit;
            TX_STOP1:  frame_done = tick && !fmt_q.two_stop;
            TX_STOP2:  frame_done = tick;
            default:   line = 1'b1;
        endcase
    end

    assign ones = fmt.word8 ? ^data : ^data[6:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q   <= '0;
            shreg   <= '0;
            bit_idx <= '0;
            par_bit <= 1'b0;
        end else if (take) begin
            fmt_q   <= fmt;
            shreg   <= data;
            bit_idx <= '0;
            par_bit <= fmt.par_even ? ones : ~ones;
        end else if (state == TX_DATA && tick) begin
            shreg   <= shreg >> 1;
            bit_idx <= bit_idx + 1'b1;
        end
    end

    // R2
    start_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE && avail) |=> (state == TX_START));
    // R4
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TX_IDLE && !tick) |=> $stable(state));
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DIV_W = 8,
    localparam int LW   = $clog2(DEPTH + 1),
    localparam int CW   = DIV_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_wr,
    input  logic [7:0]       fifo_wdata,
    output logic [31:0]      fifo_rdata,
    input  logic [31:0]      lcr,
    input  logic [DIV_W-1:0] divisor,
    input  logic             iclr_wr,
    input  logic [31:0]      iclr_data,
    output logic [7:0]       int_status,
    output logic             txd
);
    logic [7:0]    q_data;
    logic [LW-1:0] q_level;
    logic          take, line, frame_done, tick;
    tx_state_e     fr_state;
    frame_fmt_t    fmt;
    logic          drained_evt, quiet_evt;
    logic [1:0]    flags;
    logic          side_unused;

    assign fmt = '{word8:    lcr[LC_WORD8],
                   par_en:   lcr[LC_PAR_EN],
                   par_even: lcr[LC_PAR_EVEN],
                   two_stop: lcr[LC_TWO_STOP]};

    assign side_unused = ^{lcr[31], lcr[29], lcr[25], lcr[23:19], lcr[17:0],
                           iclr_data[31:8], iclr_data[5:0]};

    tx_queue #(.DEPTH(DEPTH), .W(8)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_wr),
        .wdata (fifo_wdata),
        .pop   (take),
        .flush (lcr[LC_FLUSH]),
        .rdata (q_data),
        .level (q_level)
    );

    tx_bit_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (fr_state != TX_IDLE),
        .limit ({divisor, 4'hF}),
        .tick  (tick)
    );

    tx_framer u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .avail      (q_level != '0),
        .data       (q_data),
        .fmt        (fmt),
        .tick       (tick),
        .take       (take),
        .line       (line),
        .frame_done (frame_done),
        .state      (fr_state)
    );

    assign drained_evt = take && (q_level == LW'(1)) && !fifo_wr;
    assign quiet_evt   = frame_done && (q_level == '0) && !fifo_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            txd   <= 1'b1;
        end else begin
            flags <= (flags & ~({2{iclr_wr}} & iclr_data[ST_DRAINED:ST_QUIET]))
                   | {drained_evt, quiet_evt};
            txd   <= lcr[LC_BREAK] ? 1'b0 : line;
        end
    end

    always_comb begin
        int_status = '0;
        int_status[ST_DRAINED] = flags[1];
        int_status[ST_QUIET]   = flags[0];
        fifo_rdata = '0;
        fifo_rdata[LEVEL_LSB +: LW] = q_level;
    end

    // R7
    break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcr[LC_BREAK] |=> !txd);
    // R8
    drained_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && q_level == LW'(1) && !fifo_wr) |=> int_status[ST_DRAINED]);
    // R9
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_status[ST_QUIET]) |-> (fr_state == TX_IDLE));
endmodule

// File: tb/tb_uart_tx_path.sv
module tb_uart_tx_path;
    localparam int DEPTH = 16;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fifo_wr = 1'b0;
    logic [7:0]       fifo_wdata = '0;
    logic [31:0]      fifo_rdata;
    logic [31:0]      lcr = '0;
    logic [DIV_W-1:0] divisor = '0;
    logic             iclr_wr = 1'b0;
    logic [31:0]      iclr_data = '0;
    logic [7:0]       int_status;
    logic             txd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    uart_tx_path #(.DEPTH(DEPTH), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .fifo_rdata(fifo_rdata), .lcr(lcr), .divisor(divisor),
        .iclr_wr(iclr_wr), .iclr_data(iclr_data), .int_status(int_status), .txd(txd)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_lcr(input bit w8, input bit pen, input bit peven, input bit two);
        logic [31:0] v = '0;
        v[24] = w8; v[27] = pen; v[28] = peven; v[26] = two;
        return v;
    endfunction

    function automatic logic [11:0] exp_frame(input logic [7:0] d, input bit w8, input bit pen,
                                              input bit peven, input bit two, output int n);
        logic [11:0] f = '1;
        int k = 1;
        logic ones;
        f[0] = 1'b0;
        for (int i = 0; i < (w8 ? 8 : 7); i++) begin f[k] = d[i]; k++; end
        if (pen) begin
            ones = w8 ? ^d : ^d[6:0];
            f[k] = peven ? ones : ~ones;
            k++;
        end
        f[k] = 1'b1; k++;
        if (two) begin f[k] = 1'b1; k++; end
        n = k;
        return f;
    endfunction

    task automatic push(input logic [7:0] d);
        @(negedge clk); fifo_wr = 1'b1; fifo_wdata = d;
        @(negedge clk); fifo_wr = 1'b0;
    endtask

    task automatic clear(input logic [31:0] m);
        @(negedge clk); iclr_wr = 1'b1; iclr_data = m;
        @(negedge clk); iclr_wr = 1'b0; iclr_data = '0;
    endtask

    task automatic capture(input int n, input int t, output logic [11:0] got);
        int guard = 0;
        got = '1;
        while (txd !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
        repeat (t / 2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            got[i] = txd;
            if (i < n - 1) repeat (t) @(negedge clk);
        end
    endtask

    task automatic wait_quiet();
        int guard = 0;
        while (int_status[6] !== 1'b1 && guard < 20000) begin @(negedge clk); guard++; end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [11:0] got, exp;
        int n, t, cnt;
        logic [7:0] d;
        logic [7:0] q [3];
        bit w8, pen, pev, two;
        void'($urandom(32'hA5C3_0917));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state, R1 level field
        chk(fifo_rdata == 32'h0, "R1 reset level", fifo_rdata, 0);
        chk(int_status == 8'h0, "R10 reset status", int_status, 0);
        chk(txd == 1'b1, "R10 reset line high", txd, 1);

        // R4 start bit length with divisor 1
        lcr = mk_lcr(1, 0, 0, 0); divisor = 8'd1;
        push(8'h01);
        while (txd !== 1'b0) @(negedge clk);
        cnt = 0;
        while (txd === 1'b0 && cnt < 1000) begin cnt++; @(negedge clk); end
        chk(cnt == 32, "R4 start bit length", cnt, 32);
        wait_quiet();
        clear(32'hC0);
        chk(int_status == 8'h0, "R10 clear both", int_status, 0);

        // R8 drained flag timing, R9 quiet flag timing
        divisor = 8'd0;
        push(8'hB6);
        chk(int_status[7] == 1'b0, "R8 not yet drained", int_status[7], 0);
        @(negedge clk);
        chk(int_status[7] == 1'b1, "R8 drained one cycle after take", int_status[7], 1);
        exp = exp_frame(8'hB6, 1, 0, 0, 0, n);
        capture(n, 16, got);
        chk(got == exp, "R2 frame 0xB6 8N1", got, exp);
        chk(int_status[6] == 1'b0, "R9 quiet not during stop bit", int_status[6], 0);
        repeat (16) @(negedge clk);
        chk(int_status[6] == 1'b1, "R9 quiet after stop", int_status[6], 1);
        clear(32'h80);
        chk(int_status == 8'h40, "R10 clear drained only", int_status, 8'h40);
        clear(32'h40);
        chk(int_status == 8'h00, "R10 clear quiet", int_status, 0);

        // R5 overrun and R1 field position
        divisor = 8'd7;
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            fifo_wr = 1'b1; fifo_wdata = 8'(i); @(negedge clk);
        end
        fifo_wr = 1'b0;
        chk(fifo_rdata == (32'(DEPTH) << 16), "R5 R1 level saturates at 16", fifo_rdata, 32'(DEPTH) << 16);
        push(8'hEE);
        chk(fifo_rdata[20:16] == 5'd16, "R5 push when full ignored", fifo_rdata[20:16], 16);

        // R6 flush
        @(negedge clk); lcr[18] = 1'b1;
        @(negedge clk); lcr[18] = 1'b0;
        chk(fifo_rdata == 32'h0, "R6 flush empties", fifo_rdata, 0);
        wait_quiet();
        clear(32'hC0);
        chk(fifo_rdata[20:16] == 5'd0, "R6 level stays empty", fifo_rdata[20:16], 0);

        // R7 break
        @(negedge clk); lcr[30] = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            chk(txd == 1'b0, "R7 break holds low", txd, 0);
            @(negedge clk);
        end
        lcr[30] = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R7 line high after break", txd, 1);

        // R2 R3 R4 random formats and bursts
        for (int f = 0; f < 40; f++) begin
            w8 = 1'($urandom); pen = 1'($urandom); pev = 1'($urandom); two = 1'($urandom);
            @(negedge clk);
            lcr = mk_lcr(w8, pen, pev, two);
            divisor = 8'($urandom_range(0, 2));
            t = 16 * (int'(divisor) + 1);
            cnt = $urandom_range(1, 3);
            for (int i = 0; i < cnt; i++) begin
                d = 8'($urandom);
                if (f < 2) d = (f == 0) ? 8'h00 : 8'hFF;
                q[i] = d;
                push(d);
            end
            for (int i = 0; i < cnt; i++) begin
                exp = exp_frame(q[i], w8, pen, pev, two, n);
                capture(n, t, got);
                chk(got == exp, $sformatf("R2 R3 R4 frame %0d.%0d fmt=%0d%0d%0d%0d", f, i, w8, pen, pev, two),
                    got, exp);
            end
            wait_quiet();
            chk(int_status[6] == 1'b1, "R9 quiet after burst", int_status[6], 1);
            clear(32'hC0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule